// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Detector

This block is the bus-master sequencer for the reset step of an open-drain single-wire bus. A one-cycle `start_i` makes it pull the line low for the reset time. It then lets the line go and listens for the whole response window. While it listens, it samples the synchronized line twice. The first sample, taken just after release, must see the line high, because only the pullup should be driving it then. The second sample, taken later, looks for the low presence pulse that any attached target sends back.

All timing is counted in ticks of an external one-microsecond strobe `us_tick_i`, so the system clock frequency does not matter. The speed class (regular or overdrive) is captured when the sequence starts and holds until it ends. At the end, the block raises `done_o` for one clock and updates a 2-bit result code in the same cycle. The code reports target present, no target, or bus error. The code is written on every completion, including the error case, and holds until the next completion. The control pins are level or pulse signals with no handshake. A `start_i` that arrives while a sequence is running is dropped.

Top module: `owrp_reset_presence`

## Requirements
- R1: After reset, `pull_n_o` is 1 (line released), `done_o` is 0 and `result_o` is 2'b01 (no target).
- R2: At regular speed (`overdrive_i`=0 when started), `pull_n_o` is held low for RST_LOW_STD microsecond ticks (default 480) from the clock after `start_i`.
- R3: At overdrive speed (`overdrive_i`=1 when started), `pull_n_o` is held low for RST_LOW_FAST ticks (default 56, inside the 48 to 80 µs range).
- R4: After the low phase, `pull_n_o` stays high for the whole listen window of LISTEN_STD ticks (480) or LISTEN_FAST ticks (48). `done_o` is then high for exactly one clock, with `pull_n_o` high.
- R5: If the line is high at the bus-error check point and low at the presence sample point (70 µs regular, 8 µs overdrive after release), the result is 2'b00 (target present).
- R6: If the line is high at both check points, the result is 2'b01 (no target). This holds even when a low pulse occurs inside the window but entirely before or entirely after the presence sample point.
- R7: If the line is low at the bus-error check point (3 µs regular, 1 µs overdrive after release), the result is 2'b10 (bus error). This outcome wins over a later presence pulse.
- R8: `result_o` changes only in the cycle in which `done_o` is high, and otherwise holds its last value.
- R9: A `start_i` pulse during the low phase or the listen window is ignored. Timing is unchanged, `done_o` fires once, and no new sequence follows.
- R10: The speed class is taken from `overdrive_i` in the start cycle. Changing `overdrive_i` during a sequence does not alter that sequence's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle strobe once per microsecond |
| start_i | input | 1 | Start pulse for a reset-and-listen sequence (taken when idle) |
| overdrive_i | input | 1 | Speed select: 0 regular, 1 overdrive |
| line_i | input | 1 | Synchronized bus line level |
| pull_n_o | output | 1 | Active-low pull-down enable for the open-drain driver |
| done_o | output | 1 | One-cycle pulse at the end of the listen window |
| result_o | output | 2 | 00 target present, 01 no target, 10 bus error |

## Verification
The bench builds the block with its default parameters, which are the real bus timings: 480/56 µs low, 480/48 µs listen, error checks at 3/1 µs and presence samples at 70/8 µs. It drives the microsecond strobe once every four clocks. Each start therefore lands at a different phase of the strobe, and every duration is checked against a window one tick wide. A behavioural target model releases, holds low, or pulses the line at chosen microsecond offsets. This places pulses on both sides of each sample point and keeps them clear of any tick uncertainty.

// File: rtl/owrp_pkg.sv
package owrp_pkg;

  typedef enum logic [1:0] {
    RES_PRESENT = 2'b00,
    RES_NONE    = 2'b01,
    RES_BUSERR  = 2'b10
  } owrp_result_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_LISTEN
  } owrp_state_e;

  localparam int unsigned PROBE_ERR  = 0;
  localparam int unsigned PROBE_PRES = 1;
  localparam int unsigned NUM_PROBES = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owrp_phase_timer.sv
module owrp_phase_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (tick_i)  count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign last_o  = tick_i && (count_q == limit_i - 1'b1);

  // R4
  count_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (count_q < limit_i));

endmodule

// File: rtl/owrp_line_probe.sv
module owrp_line_probe #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          enable_i,
  input  logic          tick_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] at_i,
  input  logic          line_i,
  output logic          low_seen_o
);

  logic low_q;
  logic hit;

  assign hit = enable_i && tick_i && (count_i == at_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_q <= 1'b0;
    else if (arm_i) low_q <= 1'b0;
    else if (hit)   low_q <= !line_i;
  end

  assign low_seen_o = low_q;

  // R7
  sample_only_listen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !enable_i) |=> $stable(low_seen_o));

endmodule

// File: rtl/owrp_seq_ctrl.sv
module owrp_seq_ctrl
  import owrp_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         speed_i,
  input  logic         last_i,
  input  logic         err_low_i,
  input  logic         pres_low_i,
  output logic         idle_o,
  output logic         low_o,
  output logic         listen_o,
  output logic         od_o,
  output logic         pull_n_o,
  output logic         done_o,
  output owrp_result_e result_o
);

  owrp_state_e  state_q;
  logic         od_q;
  logic         pull_n_q;
  logic         done_q;
  owrp_result_e result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      od_q     <= 1'b0;
      pull_n_q <= 1'b1;
      done_q   <= 1'b0;
      result_q <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_LOW;
            od_q     <= speed_i;
            pull_n_q <= 1'b0;
          end
        end
        ST_LOW: begin
          if (last_i) begin
            state_q  <= ST_LISTEN;
            pull_n_q <= 1'b1;
          end
        end
        ST_LISTEN: begin
          if (last_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (err_low_i)       result_q <= RES_BUSERR;
            else if (pres_low_i) result_q <= RES_PRESENT;
            else                 result_q <= RES_NONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign low_o    = (state_q == ST_LOW);
  assign listen_o = (state_q == ST_LISTEN);
  assign od_o     = od_q;
  assign pull_n_o = pull_n_q;
  assign done_o   = done_q;
  assign result_o = result_q;

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  released_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> pull_n_q);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_q) |-> done_q);

  // R10
  speed_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(od_q));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LISTEN && start_i && !last_i) |=> (state_q == ST_LISTEN));

endmodule

// File: rtl/owrp_reset_presence.sv
module owrp_reset_presence
  import owrp_pkg::*;
#(
  parameter int unsigned RST_LOW_STD  = 480,
  parameter int unsigned RST_LOW_FAST = 56,
  parameter int unsigned LISTEN_STD   = 480,
  parameter int unsigned LISTEN_FAST  = 48,
  parameter int unsigned ERRCHK_STD   = 3,
  parameter int unsigned ERRCHK_FAST  = 1,
  parameter int unsigned PRES_STD     = 70,
  parameter int unsigned PRES_FAST    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       us_tick_i,
  input  logic       start_i,
  input  logic       overdrive_i,
  input  logic       line_i,
  output logic       pull_n_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  localparam int unsigned TMAX = max_u(max_u(RST_LOW_STD, RST_LOW_FAST),
                                       max_u(LISTEN_STD, LISTEN_FAST));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic          idle, low_ph, listen, od_q, last;
  logic [CW-1:0] count, limit, lim_low, lim_listen;
  logic [CW-1:0] probe_at [NUM_PROBES];
  logic [NUM_PROBES-1:0] probe_low;
  owrp_result_e  res_e;

  assign lim_low    = od_q ? CW'(RST_LOW_FAST) : CW'(RST_LOW_STD);
  assign lim_listen = od_q ? CW'(LISTEN_FAST)  : CW'(LISTEN_STD);
  assign limit      = low_ph ? lim_low : lim_listen;

  assign probe_at[PROBE_ERR]  = od_q ? CW'(ERRCHK_FAST) : CW'(ERRCHK_STD);
  assign probe_at[PROBE_PRES] = od_q ? CW'(PRES_FAST)   : CW'(PRES_STD);

  owrp_phase_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (idle || last),
    .tick_i  (us_tick_i),
    .limit_i (limit),
    .count_o (count),
    .last_o  (last)
  );

  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
    owrp_line_probe #(.CW(CW)) u_probe (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (idle),
      .enable_i   (listen),
      .tick_i     (us_tick_i),
      .count_i    (count),
      .at_i       (probe_at[p]),
      .line_i     (line_i),
      .low_seen_o (probe_low[p])
    );
  end

  owrp_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .speed_i    (overdrive_i),
    .last_i     (last),
    .err_low_i  (probe_low[PROBE_ERR]),
    .pres_low_i (probe_low[PROBE_PRES]),
    .idle_o     (idle),
    .low_o      (low_ph),
    .listen_o   (listen),
    .od_o       (od_q),
    .pull_n_o   (pull_n_o),
    .done_o     (done_o),
    .result_o   (res_e)
  );

  assign result_o = res_e;

  // R2
  low_only_in_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pull_n_o |-> !done_o);

endmodule

// File: tb/owrp_reset_presence_test.sv
module owrp_reset_presence_test;

  localparam int TP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       start = 1'b0;
  logic       overdrive = 1'b0;
  logic       line = 1'b1;
  logic       pull_n;
  logic       done;
  logic [1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int stuck_us = 0;
  int ps_us = 0;
  int pe_us = 0;
  int rel = 100000;
  int phase = 0;

  always #2 clk = ~clk;

  owrp_reset_presence uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .us_tick_i   (us_tick),
    .start_i     (start),
    .overdrive_i (overdrive),
    .line_i      (line),
    .pull_n_o    (pull_n),
    .done_o      (done),
    .result_o    (result)
  );

  // microsecond strobe and target model
  initial begin
    forever begin
      @(negedge clk);
      phase   = (phase + 1) % TP;
      us_tick = (phase == 0);
      if (!pull_n) begin
        rel  = 0;
        line = 1'b0;
      end else begin
        rel  = rel + 1;
        line = !((rel < stuck_us * TP) || (rel >= ps_us * TP && rel < pe_us * TP));
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_seq(input bit od, input int st, input int ps, input int pe,
                         input logic [1:0] exp, input string tag,
                         input bit busy_start, input bit flip_speed);
    int low_c = 0, rel_c = 0, guard = 0;
    bit seen_rel = 0, relow = 0, bad_hold = 0;
    logic [1:0] prev;
    int lo_len, li_len;
    prev = result;
    stuck_us = st; ps_us = ps; pe_us = pe;
    lo_len = od ? 56 : 480;
    li_len = od ? 48 : 480;
    @(negedge clk); start = 1'b1; overdrive = od;
    @(negedge clk); start = 1'b0;
    forever begin
      if (done) break;
      if (!pull_n) begin
        if (seen_rel) relow = 1;
        low_c++;
      end else if (low_c > 0) begin
        seen_rel = 1;
        rel_c++;
      end
      if (result !== prev) bad_hold = 1;
      @(negedge clk);
      start = busy_start && ((low_c == 10 && !seen_rel) || rel_c == 100);
      if (flip_speed && low_c == 5) overdrive = !od;
      guard++;
      if (guard > 20000) break;
    end
    start = 1'b0;
    check(done === 1'b1, {tag, " R4 done seen"}, int'(done), 1);
    check(result === exp, {tag, " R5/R6/R7 result"}, int'(result), int'(exp));
    check(low_c >= (lo_len - 1) * TP + 1 && low_c <= lo_len * TP,
          od ? {tag, " R3 low time"} : {tag, " R2 low time"}, low_c, lo_len * TP);
    check(rel_c >= (li_len - 1) * TP + 1 && rel_c <= li_len * TP,
          {tag, " R4 listen time"}, rel_c, li_len * TP);
    check(!relow, {tag, " R4 line held released"}, int'(relow), 0);
    check(!bad_hold, {tag, " R8 result held before done"}, int'(bad_hold), 0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R4 done one cycle"}, int'(done), 0);
    begin
      bit again = 0;
      for (int i = 0; i < 40; i++) begin
        if (!pull_n || done || result !== exp) again = 1;
        @(negedge clk);
      end
      check(!again, {tag, " R8 R9 idle after done"}, int'(again), 0);
    end
    overdrive = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(pull_n === 1'b1, "R1 pull_n", int'(pull_n), 1);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(result === 2'b01, "R1 result", int'(result), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_std_present();   run_seq(0, 0, 20, 150, 2'b00, "std present R5", 0, 0); endtask
  task automatic t_std_none();      run_seq(0, 0, 0, 0, 2'b01, "std none R6", 0, 0); endtask
  task automatic t_std_early();     run_seq(0, 0, 20, 60, 2'b01, "std early pulse R6", 0, 0); endtask
  task automatic t_std_late();      run_seq(0, 0, 75, 200, 2'b01, "std late pulse R6", 0, 0); endtask
  task automatic t_std_err();       run_seq(0, 5, 20, 150, 2'b10, "std bus error R7", 0, 0); endtask
  task automatic t_od_present();    run_seq(1, 0, 3, 15, 2'b00, "od present R5", 0, 0); endtask
  task automatic t_od_none();       run_seq(1, 0, 0, 0, 2'b01, "od none R6", 0, 0); endtask
  task automatic t_od_err();        run_seq(1, 2, 3, 15, 2'b10, "od bus error R7", 0, 0); endtask
  task automatic t_busy_start();    run_seq(0, 0, 20, 150, 2'b00, "busy start R9", 1, 0); endtask
  task automatic t_flip_std();      run_seq(0, 0, 20, 150, 2'b00, "speed lock std R10", 0, 1); endtask
  task automatic t_flip_od();       run_seq(1, 0, 3, 15, 2'b00, "speed lock od R10", 0, 1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    t_reset();
    t_std_present();
    t_std_none();
    t_std_early();
    t_std_late();
    t_std_err();
    t_od_present();
    t_od_none();
    t_od_err();
    t_std_present();
    t_busy_start();
    t_flip_std();
    t_flip_od();
    summary();
  end

endmodule